// File: doc/BRIEF.md
# Three-Point Peak Tracking Controller

This block turns three power readings, taken at a centre frequency and at one spacing step below and above it, into a small signed correction in whole hertz. It is the decision part of a slow tracking loop. Another block measures the three powers. The correction this block produces is added to an oscillator setting by the surrounding logic. One strobe carries one measurement. After a fixed number of cycles, one valid pulse carries the answer.

When the three readings bend downward, the curvature term is negative and the block trusts a parabola fitted through the points. It estimates how far the peak sits from the centre, smooths that estimate with a one-quarter first-order filter and scales it by one quarter. It adds the result to an accumulator that keeps eight fractional bits. The whole-hertz part of the accumulator is clamped and sent out, and only the leftover fraction stays in the accumulator.

When the curvature is zero or positive, the parabola cannot be trusted. The block then falls back to a cautious estimate built from the imbalance between the two side powers. This fallback has a deadband around balance and a tighter clamp, and it leaves the filter and the accumulator untouched. A single shared restoring divider serves both paths.

Top module: `ptk_tracker`

## Requirements
- R1: After reset, `corr` is 0 and `corr_vld` is 0, and the filtered error and the accumulator both start at zero. The first update after reset is computed from zero state.
- R2: A strobe is accepted only while no update is in progress. `corr_vld` rises for exactly one cycle, HW+PW+FRAC+1 cycles after the accepting clock edge (33 with the defaults). Strobes that arrive while an update is in progress are ignored.
- R3: `corr` is 0 in every cycle in which `corr_vld` is low.
- R4: Let D = L + R − 2C, where L, C and R are `pwr_lo`, `pwr_mid` and `pwr_hi`. If D < 0, the error in 8-fractional-bit fixed point is e = ±floor(h·|R−L|·256 / (2·|D|)). It is positive when R > L and negative when L > R, and h is `spacing`.
- R5: In the trusted case the filter state updates as ef ← ef + ((e − ef) >>> 2), where >>> is an arithmetic shift and so rounds toward minus infinity.
- R6: In the trusted case the accumulator updates as acc ← acc + (ef >>> 2). The output is c = floor(acc / 256), clamped, and c·256 is then subtracted from acc.
- R7: In the trusted case the correction is limited to the range −2 to +2.
- R8: If D ≥ 0 and the update is outside the deadband, the correction is ±min(floor(h·|R−L| / (4·(L+R))), 1). Its sign follows the R > L test, and the filter and accumulator keep their values.
- R9: If D ≥ 0 and 8·|R−L| ≤ L+R (the deadband, which includes all-zero powers), the correction is 0 and the filter and accumulator keep their values.
- R10: Because the fraction is kept, a steady sub-hertz error eventually produces a +1 correction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_stb | input | 1 | Start an update with the present inputs |
| pwr_lo | input | PW (16) | Power at centre minus spacing |
| pwr_mid | input | PW (16) | Power at centre |
| pwr_hi | input | PW (16) | Power at centre plus spacing |
| spacing | input | HW (8) | Spacing h in hertz |
| corr | output | CW (3) | Signed correction in hertz, two's complement |
| corr_vld | output | 1 | One-cycle pulse marking a fresh correction |

## Verification
The directed cases cover the following:
- A symmetric peak, which must give zero error.
- Mirrored strongly lopsided peaks, which separate the clamp from the sign handling.
- Mirrored flat-or-rising triples, which must take the weak path with its one-hertz limit.
- Balanced and all-zero triples, which must land in the deadband.

A long run of one steady, small offset shows whether the fraction is carried or dropped. The check after each weak or deadband update shows whether those paths disturbed the filter. Random peaked, flat and mixed triples with random spacing then compare every result against a bench model. A strobe issued mid-update shows whether a busy block really ignores new input.

// File: rtl/ptk_pkg.sv
package ptk_pkg;

   // Which path an accepted update follows
   typedef enum logic [1:0] {
      PTK_VERTEX = 2'd0,   // curvature negative: parabola fit
      PTK_WEAK   = 2'd1,   // fallback on side imbalance
      PTK_HOLD   = 2'd2    // inside deadband: no action
   } ptk_mode_e;

endpackage

// File: rtl/ptk_operand.sv
// Combinational front end: classifies the triple and prepares divider operands.
module ptk_operand
   import ptk_pkg::*;
#(
   parameter int PW    = 16,
   parameter int HW    = 8,
   parameter int FRAC  = 8,
   parameter int DB_SH = 3
) (
   input  logic [PW-1:0]              pl,
   input  logic [PW-1:0]              pc,
   input  logic [PW-1:0]              pr,
   input  logic [HW-1:0]              h,
   output ptk_mode_e                  mode,
   output logic                       neg,
   output logic [HW+PW+FRAC-1:0]      num,
   output logic [PW+2:0]              den
);
   localparam int QW = HW + PW + FRAC;
   localparam int DW = PW + 3;
   localparam int PH = HW + PW;

   logic signed [PW+2:0] d_s;
   logic [PW+2:0]        dmag;
   logic [PW-1:0]        dif;
   logic [PW:0]          sum;
   logic [PH-1:0]        prod;
   logic                 dead;

   always_comb begin
      d_s  = $signed({3'b000, pl}) + $signed({3'b000, pr})
           - $signed({2'b00, pc, 1'b0});
      dmag = d_s[PW+2] ? $unsigned(-d_s) : $unsigned(d_s);
      neg  = (pl > pr);
      dif  = neg ? (pl - pr) : (pr - pl);
      sum  = {1'b0, pl} + {1'b0, pr};
      prod = PH'(h) * PH'(dif);
      num  = QW'({prod, {FRAC{1'b0}}});
   end

   // Deadband variant chosen by the shift parameter
   generate
      if (DB_SH == 0) begin : g_db_exact
         assign dead = (dif == '0);
      end else begin : g_db_ratio
         localparam int MW = PW + DB_SH + 1;
         assign dead = ((MW'(dif) << DB_SH) <= MW'(sum));
      end
   endgenerate

   always_comb begin
      if (d_s[PW+2]) begin
         mode = PTK_VERTEX;
         den  = DW'(dmag << 1);
      end else begin
         mode = dead ? PTK_HOLD : PTK_WEAK;
         den  = {sum, 2'b00};
      end
   end

endmodule

// File: rtl/ptk_divider.sv
// Restoring unsigned divider, one quotient bit per clock.
module ptk_divider #(
   parameter int NW = 32,
   parameter int DW = 19
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [NW-1:0] num,
   input  logic [DW-1:0] den,
   output logic [NW-1:0] quo,
   output logic          done
);
   localparam int CNTW = $clog2(NW + 1);

   logic [DW-1:0]   rem;
   logic [DW-1:0]   dvs;
   logic [CNTW-1:0] cnt;
   logic            run;
   logic [DW:0]     trial;
   logic [DW+1:0]   diffv;
   logic            take;

   always_comb begin
      trial = {rem, quo[NW-1]};
      diffv = {1'b0, trial} - {2'b00, dvs};
      take  = ~diffv[DW+1];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rem  <= '0;
         dvs  <= '0;
         quo  <= '0;
         cnt  <= '0;
         run  <= 1'b0;
         done <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start) begin
            quo <= num;
            dvs <= den;
            rem <= '0;
            cnt <= '0;
            run <= 1'b1;
         end else if (run) begin
            rem <= take ? diffv[DW-1:0] : trial[DW-1:0];
            quo <= {quo[NW-2:0], take};
            cnt <= cnt + 1'b1;
            if (cnt == CNTW'(NW - 1)) begin
               run  <= 1'b0;
               done <= 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/ptk_loop.sv
// Error filter, gain, fractional accumulator and output clamps.
module ptk_loop
   import ptk_pkg::*;
#(
   parameter int QW     = 32,
   parameter int FRAC   = 8,
   parameter int FSH    = 2,
   parameter int GSH    = 2,
   parameter int NCLAMP = 2,
   parameter int WCLAMP = 1,
   parameter int AW     = 48,
   parameter int CW     = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 fire,
   input  ptk_mode_e            mode,
   input  logic                 neg,
   input  logic [QW-1:0]        quo,
   output logic signed [CW-1:0] corr,
   output logic                 corr_vld
);
   localparam int EW = QW + 2;
   localparam int IW = QW - FRAC;
   localparam logic signed [AW-1:0] CL_HI = AW'(NCLAMP);
   localparam logic signed [AW-1:0] CL_LO = -CL_HI;

   logic signed [EW-1:0] e_s, ef_q, ef_nx;
   logic signed [AW-1:0] acc_q, acc_sum, acc_nx, ip, ipc;
   logic signed [CW-1:0] vc, wm, wc;
   logic [IW-1:0]        wmag;

   always_comb begin
      e_s = neg ? -$signed({2'b00, quo}) : $signed({2'b00, quo});
   end

   // Smoothing variant: a zero shift bypasses the filter
   generate
      if (FSH == 0) begin : g_nofilt
         assign ef_nx = e_s;
      end else begin : g_filt
         assign ef_nx = ef_q + ((e_s - ef_q) >>> FSH);
      end
   endgenerate

   always_comb begin
      acc_sum = acc_q + AW'(ef_nx >>> GSH);
      ip      = acc_sum >>> FRAC;
      if (ip > CL_HI)      ipc = CL_HI;
      else if (ip < CL_LO) ipc = CL_LO;
      else                 ipc = ip;
      vc      = CW'(ipc);
      acc_nx  = acc_sum - (AW'(vc) <<< FRAC);
      wmag    = quo[QW-1:FRAC];
      wm      = (wmag >= IW'(WCLAMP)) ? CW'(WCLAMP) : CW'(wmag);
      wc      = neg ? -wm : wm;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ef_q     <= '0;
         acc_q    <= '0;
         corr     <= '0;
         corr_vld <= 1'b0;
      end else begin
         corr_vld <= fire;
         corr     <= '0;
         if (fire) begin
            unique case (mode)
               PTK_VERTEX: begin
                  ef_q  <= ef_nx;
                  acc_q <= acc_nx;
                  corr  <= vc;
               end
               PTK_WEAK: corr <= wc;
               default:  corr <= '0;
            endcase
         end
      end
   end

endmodule

// File: rtl/ptk_tracker.sv
// Top: three-point peak tracking controller.
module ptk_tracker
   import ptk_pkg::*;
#(
   parameter int PW     = 16,
   parameter int HW     = 8,
   parameter int FRAC   = 8,
   parameter int DB_SH  = 3,
   parameter int FSH    = 2,
   parameter int GSH    = 2,
   parameter int NCLAMP = 2,
   parameter int WCLAMP = 1,
   parameter int AW     = 48,
   parameter int CW     = $clog2(NCLAMP + 1) + 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 upd_stb,
   input  logic [PW-1:0]        pwr_lo,
   input  logic [PW-1:0]        pwr_mid,
   input  logic [PW-1:0]        pwr_hi,
   input  logic [HW-1:0]        spacing,
   output logic signed [CW-1:0] corr,
   output logic                 corr_vld
);
   localparam int QW  = HW + PW + FRAC;
   localparam int DW  = PW + 3;
   localparam int LAT = QW + 1;

   // Elaboration-time parameter checks
   generate
      if (FRAC < 8) begin : g_bad_frac
         $error("ptk_tracker: FRAC must be at least 8");
      end
      if (NCLAMP < 1 || WCLAMP < 0 || WCLAMP > NCLAMP) begin : g_bad_clamp
         $error("ptk_tracker: clamp limits out of range");
      end
      if (AW < QW + 4) begin : g_bad_acc
         $error("ptk_tracker: accumulator too narrow");
      end
      if (CW < $clog2(NCLAMP + 1) + 1) begin : g_bad_cw
         $error("ptk_tracker: correction width too narrow");
      end
   endgenerate

   logic            busy, accept, done, neg_c, neg_q;
   ptk_mode_e       mode_c, mode_q;
   logic [QW-1:0]   num_c, quo;
   logic [DW-1:0]   den_c;

   assign accept = upd_stb & ~busy;

   ptk_operand #(.PW(PW), .HW(HW), .FRAC(FRAC), .DB_SH(DB_SH)) u_opnd (
      .pl(pwr_lo), .pc(pwr_mid), .pr(pwr_hi), .h(spacing),
      .mode(mode_c), .neg(neg_c), .num(num_c), .den(den_c)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         mode_q <= PTK_HOLD;
         neg_q  <= 1'b0;
      end else if (accept) begin
         busy   <= 1'b1;
         mode_q <= mode_c;
         neg_q  <= neg_c;
      end else if (done) begin
         busy   <= 1'b0;
      end
   end

   ptk_divider #(.NW(QW), .DW(DW)) u_div (
      .clk(clk), .rst_n(rst_n), .start(accept),
      .num(num_c), .den(den_c), .quo(quo), .done(done)
   );

   ptk_loop #(.QW(QW), .FRAC(FRAC), .FSH(FSH), .GSH(GSH), .NCLAMP(NCLAMP),
              .WCLAMP(WCLAMP), .AW(AW), .CW(CW)) u_loop (
      .clk(clk), .rst_n(rst_n), .fire(done), .mode(mode_q), .neg(neg_q),
      .quo(quo), .corr(corr), .corr_vld(corr_vld)
   );

endmodule

// File: rtl/ptk_chk.sv
module ptk_chk
   import ptk_pkg::*;
#(
   parameter int LAT    = 33,
   parameter int NCLAMP = 2,
   parameter int WCLAMP = 1,
   parameter int CW     = 3
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 upd_stb,
   input logic                 busy,
   input ptk_mode_e            mode_q,
   input logic signed [CW-1:0] corr,
   input logic                 corr_vld
);
   logic        pend;
   logic [15:0] cnt;
   int          ci;

   assign ci = int'(corr);

   // Independent model of acceptance and elapsed cycles
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend <= 1'b0;
         cnt  <= '0;
      end else if (corr_vld || !pend) begin
         pend <= upd_stb;
         cnt  <= '0;
      end else begin
         cnt  <= cnt + 16'd1;
      end
   end

   // R2
   latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      corr_vld |-> (pend && cnt == 16'(LAT)));

   // R2
   accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_stb && !busy) |=> busy);

   // R2
   pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      corr_vld |=> !corr_vld);

   // R3
   idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !corr_vld |-> (corr == '0));

   // R7
   clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      corr_vld |-> (ci >= -NCLAMP && ci <= NCLAMP));

   // R8
   weak_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (corr_vld && mode_q == PTK_WEAK) |-> (ci >= -WCLAMP && ci <= WCLAMP));

   // R9
   hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (corr_vld && mode_q == PTK_HOLD) |-> (corr == '0));

endmodule

bind ptk_tracker ptk_chk #(.LAT(LAT), .NCLAMP(NCLAMP), .WCLAMP(WCLAMP), .CW(CW)) u_chk (
   .clk(clk), .rst_n(rst_n), .upd_stb(upd_stb), .busy(busy),
   .mode_q(mode_q), .corr(corr), .corr_vld(corr_vld)
);

// File: tb/sim_ptk_tracker.sv
`timescale 1ns/1ps
module sim_ptk_tracker;
   localparam int PW  = 16;
   localparam int HW  = 8;
   localparam int FRAC = 8;
   localparam int CW  = 3;
   localparam int LAT = HW + PW + FRAC + 1;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 upd_stb = 1'b0;
   logic [PW-1:0]        pwr_lo = '0, pwr_mid = '0, pwr_hi = '0;
   logic [HW-1:0]        spacing = '0;
   logic signed [CW-1:0] corr;
   logic                 corr_vld;

   int nchk = 0;
   int nerr = 0;
   longint m_ef = 0;
   longint m_acc = 0;

   always #10 clk = ~clk;   // 50 MHz

   ptk_tracker u0 (
      .clk(clk), .rst_n(rst_n), .upd_stb(upd_stb),
      .pwr_lo(pwr_lo), .pwr_mid(pwr_mid), .pwr_hi(pwr_hi), .spacing(spacing),
      .corr(corr), .corr_vld(corr_vld)
   );

   task automatic check(input string req, input longint act, input longint exp);
      nchk++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog actual hung expected done");
      finish_run();
   end

   // Reference model from the requirements; returns tag via mode code
   function automatic longint model(input longint l, input longint c, input longint r,
                                    input longint h, output int md);
      longint d, dif, q, e, ip, s, res;
      bit ng;
      d   = l + r - 2 * c;
      ng  = (l > r);
      dif = ng ? l - r : r - l;
      if (d < 0) begin                       // R4 R5 R6 R7
         md    = 0;
         q     = (h * dif * 256) / (2 * (-d));
         e     = ng ? -q : q;
         m_ef  = m_ef + ((e - m_ef) >>> 2);
         m_acc = m_acc + (m_ef >>> 2);
         ip    = m_acc >>> 8;
         res   = (ip > 2) ? 2 : ((ip < -2) ? -2 : ip);
         m_acc = m_acc - res * 256;
      end else begin
         s = l + r;
         if ((dif << 3) <= s) begin          // R9
            md  = 2;
            res = 0;
         end else begin                      // R8
            md  = 1;
            q   = (h * dif * 256) / (4 * s);
            res = q >>> 8;
            if (res > 1) res = 1;
            if (ng) res = -res;
         end
      end
      return res;
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst_n   = 1'b0;
      upd_stb = 1'b0;
      repeat (3) @(negedge clk);
      rst_n   = 1'b1;
      m_ef    = 0;
      m_acc   = 0;
   endtask

   task automatic run_upd(input int l, input int c, input int r, input int h,
                          output longint got);
      longint exp;
      int md, n;
      string tag;
      exp = model(l, c, r, h, md);
      tag = (md == 0) ? "R4 R5 R6 R7 vertex" : ((md == 1) ? "R8 weak" : "R9 deadband");
      @(negedge clk);
      pwr_lo = PW'(l); pwr_mid = PW'(c); pwr_hi = PW'(r); spacing = HW'(h);
      upd_stb = 1'b1;
      @(negedge clk);
      upd_stb = 1'b0;
      n = 0;
      while (!corr_vld && n < LAT + 10) begin
         @(negedge clk);
         n++;
      end
      check("R2 latency", n, LAT);
      got = longint'(corr);
      check(tag, got, exp);
   endtask

   initial begin
      longint g, g2, ga;
      int saw_one, extra;
      void'($urandom(32'd20240611));
      do_reset();
      @(negedge clk);
      // R1 reset state at the outputs
      check("R1 corr", longint'(corr), 0);
      check("R1 vld", longint'(corr_vld), 0);

      // R4 symmetric peak gives zero
      run_upd(100, 400, 100, 10, g);
      check("R4 symmetric", g, 0);

      // R10 steady sub-hertz offset carries its fraction to a +1
      do_reset();
      saw_one = 0;
      for (int i = 0; i < 24; i++) begin
         run_upd(300, 400, 320, 10, g);
         if (g == 1) saw_one = 1;
      end
      check("R10 carry", saw_one, 1);

      // R7 large offsets clamp both ways
      do_reset();
      run_upd(0, 1000, 999, 200, g);
      check("R7 clamp high", g, 2);
      do_reset();
      run_upd(999, 1000, 0, 200, g);
      check("R7 clamp low", g, -2);

      // R8 weak path, both signs, then state untouched by it
      do_reset();
      run_upd(0, 0, 60000, 255, g);
      check("R8 weak pos", g, 1);
      run_upd(60000, 0, 0, 255, g);
      check("R8 weak neg", g, -1);
      run_upd(0, 1000, 999, 200, g);
      check("R8 state held after weak", g, 2);

      // R9 deadband cases keep state
      do_reset();
      run_upd(500, 500, 500, 100, g);
      check("R9 flat", g, 0);
      run_upd(1000, 100, 1100, 255, g);
      check("R9 near balance", g, 0);
      run_upd(0, 0, 0, 255, g);
      check("R9 zero powers", g, 0);
      run_upd(999, 1000, 0, 200, g);
      check("R9 state held after deadband", g, -2);

      // R2 strobe during an update is ignored
      do_reset();
      ga = model(0, 1000, 999, 200, extra);
      @(negedge clk);
      pwr_lo = 16'd0; pwr_mid = 16'd1000; pwr_hi = 16'd999; spacing = 8'd200;
      upd_stb = 1'b1;
      @(negedge clk);
      upd_stb = 1'b0;
      repeat (5) @(negedge clk);
      pwr_lo = 16'd999; pwr_hi = 16'd0;
      upd_stb = 1'b1;
      @(negedge clk);
      upd_stb = 1'b0;
      extra = 0;
      g2 = 99;
      for (int i = 0; i < 2 * LAT; i++) begin
         @(negedge clk);
         if (corr_vld) begin
            extra++;
            g2 = longint'(corr);
         end
      end
      check("R2 single pulse while busy", extra, 1);
      check("R2 first strobe result", g2, ga);

      // Random mix of peaked, flat and arbitrary triples
      do_reset();
      for (int i = 0; i < 250; i++) begin
         int t, l, c, r, h;
         t = int'($urandom % 3);
         h = int'($urandom % 255) + 1;
         if (t == 0) begin
            c = int'($urandom % 65536);
            l = int'($urandom % (c + 1));
            r = int'($urandom % (c + 1));
         end else if (t == 1) begin
            c = int'($urandom % 2000);
            l = int'($urandom % 65536);
            r = int'($urandom % 65536);
         end else begin
            c = int'($urandom % 65536);
            l = int'($urandom % 65536);
            r = int'($urandom % 65536);
         end
         run_upd(l, c, r, h, g);
      end

      @(negedge clk);
      check("R3 idle corr", longint'(corr), 0);
      finish_run();
   end
endmodule